// File: doc/BRIEF.md
# Serial Display-Register Write Port

This block is an I2C target that only accepts writes. It takes the bus lines as they arrive from a host microcontroller and turns each write transaction into 16-bit word writes for an on-screen-display register RAM. Both SCL and SDA come in already synchronised to the system clock. The block samples SDA on every SCL rising edge. It answers on the bus only by pulling SDA low.

A transaction starts with the device address byte. Next come a row byte and a column byte. After these, bytes arrive in pairs and each pair forms one word, high byte first. Each finished word goes out on a valid/ready write port together with its row and column. The column then steps by one, so a burst fills neighbouring cells of the same row. The address space covers three regions:
- rows 0 to 14, columns 0 to 29: character cells;
- column 30 of the same rows: per-row attributes;
- row 15, columns 0 to 2: frame control.

The block passes every index through unchanged and does not check it against these regions.

The write port can take back-pressure. Once `wr_valid` rises, `wr_row`, `wr_col` and `wr_data` hold steady until the cycle in which `wr_ready` is high. That cycle transfers the word, exactly once. I2C gives the block no way to stall the host, so the sink must accept each word before the next low byte completes, which is at least 16 SCL periods later. If it does not, the pending word is replaced by the new one.

Top module: `osd_i2c_wr_rx`

## Requirements
- R1: The block acknowledges the first byte after a START only when it equals 0xBA, which is device address 0x5D with the R/W bit, bit 0, equal to 0. Any other first byte, including 0xBB, gets no acknowledge. After such a byte the block acknowledges nothing and writes nothing until the next START.
- R2: The byte after an acknowledged device address is the row byte. The block acknowledges it and takes bits 3..0 as the row. Bits 7..4 are ignored.
- R3: The next byte is the column byte. The block acknowledges it and takes bits 4..0 as the column. Bits 7..5 are ignored.
- R4: After the column byte, bytes pair up into words. The first byte of a pair is bits 15..8 and the second is bits 7..0. Every data byte is acknowledged. A write is issued only once the second byte is complete. Each byte is sent MSB first, with SDA sampled on the SCL rising edge.
- R5: After each word is issued, the column increases by one, modulo 32. The row stays the same.
- R6: A START or STOP that arrives while a word is half received drops that half word and writes nothing. A repeated START begins address decoding again from the device address.
- R7: The acknowledge pulls SDA low from the SCL falling edge that follows the 8th bit of a byte. It releases SDA at the next SCL falling edge. At all other times SDA is released.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_row`, `wr_col` and `wr_data` stay stable. Each word is transferred in exactly one cycle in which both are high.
- R9: After reset, `wr_valid` and `sda_pull` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, synchronised |
| sda_i | input | 1 | Bus data line as seen on the wire, synchronised |
| sda_pull | output | 1 | High pulls SDA low (open-drain drive) |
| wr_valid | output | 1 | A word write is pending |
| wr_ready | input | 1 | The sink accepts the pending word |
| wr_row | output | 4 | Row index of the pending word |
| wr_col | output | 5 | Column index of the pending word |
| wr_data | output | 16 | Word to write |

## Verification
A wrong address decode or a wrong byte role appears at the ports within one SCL period, because the acknowledge slot of that same byte carries the decision. A role sequencer that loses its place, or a half word that survives an abort, shows up at the next write strobe as a wrong column, a wrong data word or an extra write. The bench therefore checks the ACK of every byte as well as the row, column, data and number of writes after every transaction. A wrong acknowledge window shows as SDA still pulled low after the acknowledge clock ends.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    RL_IDLE, RL_DEV, RL_AHI, RL_ALO, RL_DHI, RL_DLO
  } role_e;

  typedef enum logic [1:0] {
    EN_OFF, EN_BITS, EN_ACK
  } eng_e;
endpackage

// File: rtl/osd_i2c_line_mon.sv
module osd_i2c_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  // SDA moves while SCL stays high: bus condition
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/osd_i2c_bit_engine.sv
module osd_i2c_bit_engine
  import osd_i2c_pkg::*;
#(
  parameter int NBITS = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_i,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             ack_ok,
  output logic             byte_vld,
  output logic [NBITS-1:0] byte_o,
  output logic             sda_pull
);
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NBITS);

  eng_e             st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= EN_OFF;
      cnt      <= '0;
      byte_o   <= '0;
      byte_vld <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (start_ev) begin
        st       <= EN_BITS;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st       <= EN_OFF;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          EN_BITS: begin
            if (scl_rise && cnt < FULL) begin
              byte_o <= {byte_o[NBITS-2:0], sda_i};
              cnt    <= cnt + 1'b1;
              if (cnt == LAST) byte_vld <= 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (ack_ok) begin
                st       <= EN_ACK;
                sda_pull <= 1'b1;
              end else begin
                st <= EN_OFF;
              end
            end
          end
          EN_ACK: begin
            if (scl_fall) begin
              st       <= EN_BITS;
              sda_pull <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: the pull starts only on an SCL falling edge
  p_ack_begin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  // R7: the pull ends only on an SCL falling edge or a bus condition
  p_ack_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

// File: rtl/osd_i2c_word_pack.sv
module osd_i2c_word_pack
  import osd_i2c_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              take_row,
  input  logic              take_col,
  input  logic              take_hi,
  input  logic              take_lo,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [WORD_W-1:0] wr_data
);
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_row  <= '0;
      cur_col  <= '0;
      hi_q     <= '0;
      wr_valid <= 1'b0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_data  <= '0;
    end else begin
      if (take_row) cur_row <= byte_i[ROW_W-1:0];
      if (take_hi)  hi_q    <= byte_i;
      if (take_col) begin
        cur_col <= byte_i[COL_W-1:0];
      end else if (take_lo) begin
        cur_col <= cur_col + 1'b1;
      end
      if (take_lo) begin
        wr_valid <= 1'b1;
        wr_row   <= cur_row;
        wr_col   <= cur_col;
        wr_data  <= {hi_q, byte_i};
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled word stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !take_lo) |=>
      (wr_valid && $stable(wr_data) && $stable(wr_row) && $stable(wr_col)));
endmodule

// File: rtl/osd_i2c_wr_rx.sv
module osd_i2c_wr_rx
  import osd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D,
  parameter int         ROW_W    = 4,
  parameter int         COL_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [WORD_W-1:0] wr_data
);
  localparam logic [BYTE_W-1:0] WR_CODE = {DEV_ADDR, 1'b0};

  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_vld, ack_ok;
  logic [BYTE_W-1:0] rx_byte;
  role_e role;

  osd_i2c_line_mon u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  osd_i2c_bit_engine #(.NBITS(BYTE_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .ack_ok(ack_ok),
    .byte_vld(byte_vld), .byte_o(rx_byte), .sda_pull(sda_pull)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role   <= RL_IDLE;
      ack_ok <= 1'b0;
    end else if (start_ev) begin
      role <= RL_DEV;
    end else if (stop_ev) begin
      role <= RL_IDLE;
    end else if (byte_vld) begin
      case (role)
        RL_DEV: begin
          if (rx_byte == WR_CODE) begin
            ack_ok <= 1'b1;
            role   <= RL_AHI;
          end else begin
            ack_ok <= 1'b0;
            role   <= RL_IDLE;
          end
        end
        RL_AHI:  begin ack_ok <= 1'b1; role <= RL_ALO; end
        RL_ALO:  begin ack_ok <= 1'b1; role <= RL_DHI; end
        RL_DHI:  begin ack_ok <= 1'b1; role <= RL_DLO; end
        RL_DLO:  begin ack_ok <= 1'b1; role <= RL_DHI; end
        default: ack_ok <= 1'b0;
      endcase
    end
  end

  logic take_row, take_col, take_hi, take_lo;
  assign take_row = byte_vld && role == RL_AHI;
  assign take_col = byte_vld && role == RL_ALO;
  assign take_hi  = byte_vld && role == RL_DHI;
  assign take_lo  = byte_vld && role == RL_DLO;

  osd_i2c_word_pack #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .byte_i(rx_byte),
    .take_row(take_row), .take_col(take_col),
    .take_hi(take_hi), .take_lo(take_lo),
    .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  // R1: an unaddressed target never drives the line
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (role == RL_IDLE) |-> !sda_pull);
  // R4: a new write follows a completed low byte
  p_write_on_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(role == RL_DLO));
endmodule

// File: tb/test_osd_i2c_wr_rx.sv
module test_osd_i2c_wr_rx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic wr_ready = 1'b1;
  logic sda_pull, wr_valid;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [15:0] wr_data;
  wire sda_line = sda_d & ~sda_pull;

  osd_i2c_wr_rx i_osd_i2c_wr_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_line),
    .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  int nchk = 0, nbad = 0, wcount = 0;
  bit done = 0;
  logic [3:0]  lrow [0:31];
  logic [4:0]  lcol [0:31];
  logic [15:0] ldat [0:31];

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (wcount < 32) begin
        lrow[wcount] = wr_row;
        lcol[wcount] = wr_col;
        ldat[wcount] = wr_data;
      end
      wcount = wcount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_d = 1'b1; tick(4);
    scl_d = 1'b1; tick(8);
    sda_d = 1'b0; tick(8);
    scl_d = 1'b0; tick(4);
  endtask

  task automatic i2c_stop;
    sda_d = 1'b0; tick(4);
    scl_d = 1'b1; tick(8);
    sda_d = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; tick(4);
      scl_d = 1'b1; tick(8);
      scl_d = 1'b0; tick(4);
    end
    sda_d = 1'b1; tick(4);
    scl_d = 1'b1; tick(4);
    ack = !sda_line;
    tick(4);
    scl_d = 1'b0; tick(4);
    chk("R7 line released after ack clock", sda_pull, 0);
  endtask

  // {dev, rowbyte, colbyte, dhi, dlo, ack, row, col, data}
  localparam logic [65:0] VECS [8] = '{
    {8'hBA, 8'h03, 8'h05, 8'h12, 8'h34, 1'b1, 4'd3,  5'd5,  16'h1234},
    {8'hBA, 8'hF7, 8'hE2, 8'hA5, 8'h5A, 1'b1, 4'd7,  5'd2,  16'hA55A},
    {8'hB8, 8'h03, 8'h05, 8'h12, 8'h34, 1'b0, 4'd0,  5'd0,  16'h0000},
    {8'hBB, 8'h01, 8'h01, 8'h11, 8'h22, 1'b0, 4'd0,  5'd0,  16'h0000},
    {8'hBA, 8'h0F, 8'h02, 8'h80, 8'h01, 1'b1, 4'd15, 5'd2,  16'h8001},
    {8'hBA, 8'h0E, 8'h1E, 8'hFF, 8'h00, 1'b1, 4'd14, 5'd30, 16'hFF00},
    {8'hBA, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 4'd0,  5'd0,  16'h00FF},
    {8'h3A, 8'h02, 8'h03, 8'h44, 8'h55, 1'b0, 4'd0,  5'd0,  16'h0000}
  };

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    int w0;
    tick(5);
    chk("R9 wr_valid after reset", wr_valid, 0);
    chk("R9 sda_pull after reset", sda_pull, 0);
    rst_n = 1'b1;
    tick(5);

    // vector table: one transaction per entry
    for (int v = 0; v < 8; v++) begin
      logic [65:0] e;
      e = VECS[v];
      w0 = wcount;
      i2c_start();
      send_byte(e[65:58], a);
      chk("R1 device address ack", a, e[25]);
      send_byte(e[57:50], a); chk("R2 row byte ack (R1 when ignored)", a, e[25]);
      send_byte(e[49:42], a); chk("R3 col byte ack (R1 when ignored)", a, e[25]);
      send_byte(e[41:34], a); chk("R4 high byte ack", a, e[25]);
      send_byte(e[33:26], a); chk("R4 low byte ack", a, e[25]);
      i2c_stop();
      tick(6);
      chk("R1 R4 write count", wcount - w0, e[25] ? 1 : 0);
      if (e[25] && wcount > w0) begin
        chk("R2 row", lrow[w0], e[24:21]);
        chk("R3 col", lcol[w0], e[20:16]);
        chk("R4 data", ldat[w0], e[15:0]);
      end
    end

    // R5: burst with column step and wrap
    w0 = wcount;
    i2c_start();
    send_byte(8'hBA, a); send_byte(8'h06, a); send_byte(8'h1E, a);
    send_byte(8'h11, a); send_byte(8'h11, a);
    send_byte(8'h22, a); send_byte(8'h22, a);
    send_byte(8'h33, a); send_byte(8'h33, a);
    i2c_stop(); tick(6);
    chk("R5 burst write count", wcount - w0, 3);
    chk("R5 col first", lcol[w0], 30);
    chk("R5 col second", lcol[w0+1], 31);
    chk("R5 col wraps", lcol[w0+2], 0);
    chk("R5 row kept", lrow[w0+2], 6);
    chk("R5 data third", ldat[w0+2], 16'h3333);

    // R6: STOP after a half word writes nothing
    w0 = wcount;
    i2c_start();
    send_byte(8'hBA, a); send_byte(8'h04, a); send_byte(8'h07, a);
    send_byte(8'h77, a);
    i2c_stop(); tick(6);
    chk("R6 stop drops half word", wcount - w0, 0);

    // R6: repeated START mid-word restarts decoding
    w0 = wcount;
    i2c_start();
    send_byte(8'hBA, a); send_byte(8'h05, a); send_byte(8'h09, a);
    send_byte(8'h66, a);
    scl_d = 1'b0; sda_d = 1'b1; tick(4);
    i2c_start();
    send_byte(8'hBA, a); chk("R6 address acked after repeated start", a, 1);
    send_byte(8'h05, a); send_byte(8'h0A, a);
    send_byte(8'hAB, a); send_byte(8'hCD, a);
    i2c_stop(); tick(6);
    chk("R6 single write after restart", wcount - w0, 1);
    chk("R6 col from new address", lcol[w0], 10);
    chk("R6 data from new pair", ldat[w0], 16'hABCD);

    // R8: back-pressure holds the word
    wr_ready = 1'b0;
    w0 = wcount;
    i2c_start();
    send_byte(8'hBA, a); send_byte(8'h02, a); send_byte(8'h04, a);
    send_byte(8'hBE, a); send_byte(8'hEF, a);
    i2c_stop(); tick(6);
    chk("R8 valid held", wr_valid, 1);
    chk("R8 data held", wr_data, 16'hBEEF);
    tick(20);
    chk("R8 still valid", wr_valid, 1);
    chk("R8 row stable", wr_row, 2);
    chk("R8 col stable", wr_col, 4);
    chk("R8 no transfer while stalled", wcount - w0, 0);
    wr_ready = 1'b1;
    tick(4);
    chk("R8 one transfer", wcount - w0, 1);
    chk("R8 valid drops", wr_valid, 0);
    chk("R8 transferred data", ldat[w0], 16'hBEEF);

    done = 1;
    summary();
    $finish;
  end
endmodule